// File: doc/BRIEF.md
# Serial Register Read Port (device side)

This block is the device end of a half-duplex two-wire link made of a host-driven serial clock and one shared data line. The host clocks in an address byte, most significant bit first. The device samples the line on serial-clock rising edges. If the top bit of that byte is 0, the device answers with one data byte from a small register file. It drives each data bit from a serial-clock falling edge, most significant bit first. The host clocks out the data byte on the same clock.

The serial clock is not used as a clock domain. The serial clock, the data line and the power-down input are brought into the system clock domain through a synchroniser. Edges are then found by comparing each synchronised sample with the one before it. The shared line appears as a separate output value and output enable, and a pad outside the block combines them. Raising power-down clears the frame position, so the host can realign the frame after a glitch. The register file holds fixed values that are loaded on reset. Writes are not handled.

Top module: `sregrd_port`

## Requirements
- R1: While reset is asserted and afterwards until a read frame reaches its data phase, `sdio_oe` and `sdio_out` are 0.
- R2: The first 8 serial-clock rising edges of a frame capture the address byte from `sdio_in`, most significant bit first. The top bit of that byte is the direction bit, and the low 7 bits select a register.
- R3: A read frame returns the selected register most significant bit first. Register `a` for `a` below 16 holds `(a*37 + 11) mod 256` after reset. Addresses 16 to 127 read as 0x00.
- R4: `sdio_oe` stays low throughout the address phase. It rises on the first serial-clock falling edge after the 8th rising edge.
- R5: `sdio_out` and `sdio_oe` change only on serial-clock falling edges or through power-down. Serial-clock rising edges leave them unchanged.
- R6: The last data bit stays on the line after the 16th rising edge. `sdio_oe` falls on the next falling edge, which starts the next frame.
- R7: An address byte whose top bit is 1 never enables the output during its frame.
- R8: While `pwrdn_in` is high, `sdio_oe` is 0, the frame position is cleared and serial-clock edges are ignored.
- R9: After `pwrdn_in` is released, the next rising edge is treated as address bit 7, whatever partial frame came before.
- R10: Frames follow one another back to back with no idle gap, and each returns its own register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Host serial clock, asynchronous, idles high |
| pwrdn_in | input | 1 | Power-down / frame realignment, asynchronous |
| sdio_in | input | 1 | Value seen on the shared data line |
| sdio_out | output | 1 | Value to drive onto the data line |
| sdio_oe | output | 1 | Drive enable for the data line pad |

## Verification
An edge on any serial input is seen by the block three system clocks later: two synchroniser stages, plus the edge-detect register that commits the result. Power-down clears the outputs after the same three clocks. The bench holds every serial-clock phase for 8 system clocks and samples the outputs only at the end of a phase, after that delay has passed and before the next edge. It takes one sample at the end of each low phase and one at the end of each high phase. Comparing the two samples of a cycle shows whether anything changed on a rising edge. The sample at the start of the next frame shows whether the enable dropped at the right moment.

// File: rtl/sregrd_pkg.sv
package sregrd_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int FRAME_LEN = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int IDX_W     = ADDR_W - 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CNT_W-1:0]  pos_t;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // synchronised view of the serial pins; order fixes the reset vector
    typedef struct packed {
        logic sclk;
        logic pwrdn;
        logic sdio;
    } line_t;

    localparam int LINE_W = $bits(line_t);

    function automatic byte_t preload_value(input int idx);
        return byte_t'((idx * 37 + 11) % 256);
    endfunction
endpackage

// File: rtl/sregrd_sync.sv
module sregrd_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= RST_VAL;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sregrd_regs.sv
module sregrd_regs
    import sregrd_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    output byte_t rd_data
);
    byte_t mem [NUM_REGS];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= preload_value(i);
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (int'(rd_idx) == i)
                rd_data = mem[i];
    end
endmodule

// File: rtl/sregrd_frame.sv
module sregrd_frame
    import sregrd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t ln,
    output idx_t  req_idx,
    input  byte_t req_data,
    output logic  oe,
    output logic  dout
);
    localparam pos_t LAST_ADDR = pos_t'(ADDR_W - 1);
    localparam pos_t FIRST_DAT = pos_t'(ADDR_W);
    localparam pos_t LAST_POS  = pos_t'(FRAME_LEN - 1);

    logic             sclk_d;
    pos_t             pos;
    logic [IDX_W-1:0] addr_sh;
    logic             rd_q;
    byte_t            data_sh;
    logic             rise, fall;

    assign rise    = ln.sclk & ~sclk_d;
    assign fall    = ~ln.sclk & sclk_d;
    assign req_idx = {addr_sh[IDX_W-2:0], ln.sdio};
    assign dout    = oe & data_sh[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b1;
            pos     <= '0;
            addr_sh <= '0;
            rd_q    <= 1'b0;
            data_sh <= '0;
            oe      <= 1'b0;
        end else begin
            sclk_d <= ln.sclk;
            if (ln.pwrdn) begin
                pos  <= '0;
                rd_q <= 1'b0;
                oe   <= 1'b0;
            end else if (rise) begin
                pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
                if (pos < LAST_ADDR)
                    addr_sh <= {addr_sh[IDX_W-2:0], ln.sdio};
                if (pos == LAST_ADDR) begin
                    rd_q    <= (dir_e'(addr_sh[IDX_W-1]) == DIR_READ);
                    data_sh <= req_data;
                end
            end else if (fall) begin
                if (pos == FIRST_DAT)
                    oe <= rd_q;
                else if (pos == '0)
                    oe <= 1'b0;
                else if (pos > FIRST_DAT)
                    data_sh <= {data_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    // R5
    out_only_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!fall && !ln.pwrdn) |=> ($stable(dout) && $stable(oe)));
    // R4
    oe_rise_pos_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> (pos == FIRST_DAT));
    // R6
    oe_fall_pos_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(oe) |-> (pos == '0));
    // R8
    pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ln.pwrdn |=> (!oe && pos == '0));
    // R7
    drive_only_read_chk: assert property (@(posedge clk) disable iff (rst)
        oe |-> rd_q);
endmodule

// File: rtl/sregrd_port.sv
module sregrd_port
    import sregrd_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic pwrdn_in,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe
);
    localparam line_t IDLE_LINE = '{sclk: 1'b1, pwrdn: 1'b0, sdio: 1'b0};

    line_t raw_ln, sync_ln;
    idx_t  req_idx;
    byte_t req_data;

    assign raw_ln = '{sclk: sclk_in, pwrdn: pwrdn_in, sdio: sdio_in};

    sregrd_sync #(
        .W       (LINE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LINE)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_ln),
        .q   (sync_ln)
    );

    sregrd_regs #(
        .NUM_REGS (NUM_REGS)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (req_idx),
        .rd_data (req_data)
    );

    sregrd_frame i_frame (
        .clk      (clk),
        .rst      (rst),
        .ln       (sync_ln),
        .req_idx  (req_idx),
        .req_data (req_data),
        .oe       (sdio_oe),
        .dout     (sdio_out)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!sdio_oe && !sdio_out));
endmodule

// File: tb/test_sregrd_port.sv
`timescale 1ns/1ps
module test_sregrd_port;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1;
    logic pd = 1'b0;
    logic sdi = 1'b0;
    logic sdo, oe;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sregrd_port i_sregrd_port (
        .clk      (clk),
        .rst      (rst),
        .sclk_in  (sclk),
        .pwrdn_in (pd),
        .sdio_in  (sdi),
        .sdio_out (sdo),
        .sdio_oe  (oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_val(input int a);
        return (a < 16) ? ((a * 37 + 11) % 256) : 0;
    endfunction

    task automatic run_frame(input logic [7:0] abyte, input int ncyc,
                             output logic [7:0] got, output bit addr_quiet,
                             output bit data_drive, output bit held, output bit any_oe);
        logic lo_oe, lo_out;
        got = '0; addr_quiet = 1; data_drive = 1; held = 1; any_oe = 0;
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            sclk = 1'b0;
            sdi  = (c <= 8) ? abyte[8-c] : 1'b0;
            repeat (HALF) @(negedge clk);
            lo_oe = oe; lo_out = sdo;
            if (oe) any_oe = 1;
            if (c <= 8) begin
                if (oe) addr_quiet = 0;
            end else begin
                if (!oe) data_drive = 0;
                got = {got[6:0], sdo};
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (oe) any_oe = 1;
            if (oe !== lo_oe || sdo !== lo_out) held = 0;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!oe && !sdo, "R1 outputs idle in reset", {oe, sdo}, 0);
        @(negedge clk) rst = 1'b0;
        repeat (HALF) @(negedge clk);
        chk(!oe && !sdo, "R1 outputs idle after reset", {oe, sdo}, 0);
    endtask

    task automatic t_read(input int a, input string tag);
        logic [7:0] got;
        bit aq, dd, hd, ao;
        run_frame({1'b0, 7'(a)}, 16, got, aq, dd, hd, ao);
        chk(got == 8'(exp_val(a)), {tag, " R2 R3 read data"}, got, exp_val(a));
        chk(aq, {tag, " R4 quiet in address phase"}, 0, 1);
        chk(dd, {tag, " R4 driven in data phase"}, 0, 1);
        chk(hd, {tag, " R5 no change on rising edge"}, 0, 1);
        chk(oe === 1'b1, {tag, " R6 last bit held"}, oe, 1);
    endtask

    task automatic t_write();
        logic [7:0] got;
        bit aq, dd, hd, ao;
        run_frame(8'h83, 16, got, aq, dd, hd, ao);
        chk(!ao, "R7 write frame never drives", ao, 0);
        chk(aq, "R6 drop after prior read", 0, 1);
    endtask

    task automatic t_pd_addr();
        logic [7:0] got;
        bit aq, dd, hd, ao;
        run_frame(8'h03, 5, got, aq, dd, hd, ao);
        @(negedge clk) pd = 1'b1;
        repeat (HALF) @(negedge clk);
        chk(!oe, "R8 power-down output off", oe, 0);
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b0; repeat (HALF) @(negedge clk);
            sclk = 1'b1; repeat (HALF) @(negedge clk);
        end
        chk(!oe, "R8 edges ignored in power-down", oe, 0);
        pd = 1'b0;
        repeat (HALF) @(negedge clk);
        t_read(5, "R9 resync");
    endtask

    task automatic t_pd_data();
        logic [7:0] got;
        bit aq, dd, hd, ao;
        run_frame(8'h02, 11, got, aq, dd, hd, ao);
        chk(oe === 1'b1, "R4 driving mid data", oe, 1);
        @(negedge clk) pd = 1'b1;
        repeat (HALF) @(negedge clk);
        chk(!oe && !sdo, "R8 power-down mid data", {oe, sdo}, 0);
        pd = 1'b0;
        repeat (HALF) @(negedge clk);
        t_read(9, "R9 after data abort");
    endtask

    task automatic t_b2b();
        t_read(0,   "R10 a0");
        t_read(1,   "R10 a1");
        t_read(15,  "R10 a15");
        t_read(16,  "R10 a16");
        t_read(127, "R10 a127");
        t_read(10,  "R10 a10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_read(3, "R3 basic");
        t_write();
        t_pd_addr();
        t_pd_data();
        t_b2b();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule